// File: doc/BRIEF.md
# PLL Digital Lock Detector with Automatic PA Enable

This block decides whether a frequency synthesizer has settled. It runs on a fast sampling clock and watches the up and down pulses of the phase-frequency detector. A one-cycle strobe marks the end of each reference period. At each strobe it compares the phase-error width collected over that period with a programmable window. A programmable number of consecutive in-window periods declares lock.

A policy bit selects what happens after lock. In latched mode lock stays set and later errors are ignored. In monitoring mode errors are still checked and a single bad period drops lock. Leaving the active operating modes clears the detector, and so does a change of divider ratio.

The block also drives the power-amplifier enable. In transmit mode the amplifier can be held off until lock is reported, or it can follow the transmit request directly.

The lock flag is meant to drive the shared lock-detect pin when the synthesizer is under programmed control.

Top module: `pll_lock_detect`

## Requirements
- R1: The error width of a reference period is the number of sampling-clock cycles in which `pfd_up` or `pfd_dn` is high. The count runs from the cycle after the previous `ref_tick` up to and including the cycle of the current `ref_tick`. The period is good when this width is at most the window limit: `err_sel` 0,1,2,3 selects 2,4,8,16 cycles.
- R2: `lock` rises in the cycle after the `ref_tick` that ends the N-th consecutive good period. N is selected by `cnt_sel`: 0,1,2,3 give 4,16,64,256.
- R3: While unlocked, a bad period returns the good-period count to zero.
- R4: With `recheck`=0, `lock` stays high through bad periods once set.
- R5: With `recheck`=1, a bad period while locked clears `lock` in the cycle after its `ref_tick`. Regaining lock then needs N fresh good periods.
- R6: `op_mode` is encoded {transmit, receive}: 00 standby, 01 receive, 10 transmit, 11 idle. A cycle in standby, or a cycle with `ratio_chg` high, clears `lock`, the good-period count and the width being collected.
- R7: `pa_en` is low whenever `op_mode` is not 10.
- R8: In transmit mode with `pa_auto_off`=0, `pa_en` is high exactly when `lock` is high.
- R9: In transmit mode with `pa_auto_off`=1, `pa_en` is high regardless of `lock`.
- R10: While `rst_n` is low, `lock` is low.
- R11: Down pulses count toward the error width in the same way as up pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast sampling clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pfd_up | input | 1 | phase detector up pulse |
| pfd_dn | input | 1 | phase detector down pulse |
| ref_tick | input | 1 | one-cycle strobe closing a reference period |
| err_sel | input | 2 | error window select |
| cnt_sel | input | 2 | good-period count select |
| recheck | input | 1 | 0 latch lock, 1 keep monitoring after lock |
| pa_auto_off | input | 1 | 1 disables automatic PA turn-on after lock |
| op_mode | input | 2 | operating mode {transmit, receive} |
| ratio_chg | input | 1 | divider ratio change strobe |
| lock | output | 1 | lock flag |
| pa_en | output | 1 | power amplifier enable |

## Verification
Some rules hold on every cycle, and the bound assertions check them:
- lock persistence in latched mode,
- clearing on standby or ratio change,
- lock rising only after a reference strobe,
- the power-amplifier gating rules.

Other behaviour depends on a whole history of reference periods, and only the bench scenarios can show it. This covers:
- the exact period on which lock is declared for every window and count setting,
- the reset of the count by a period one cycle over the window,
- the loss and recovery of lock in monitoring mode.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic [1:0] {
    OPM_STBY = 2'b00,
    OPM_RX   = 2'b01,
    OPM_TX   = 2'b10,
    OPM_IDLE = 2'b11
  } opmode_e;
endpackage

// File: rtl/lockdet_width_meter.sv
module lockdet_width_meter #(
  parameter int WID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic             tick,
  input  logic             clr,
  output logic [WID_W-1:0] width
);
  logic [WID_W-1:0] acc_q, acc_d;
  logic             hit;

  always_comb begin
    hit = up | dn;
    // saturating sum including the current cycle
    if (&acc_q) width = acc_q;
    else        width = acc_q + WID_W'(hit);
    if (clr || tick) acc_d = '0;
    else             acc_d = width;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/lockdet_qualifier.sv
module lockdet_qualifier #(
  parameter int WID_W = 5,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [WID_W-1:0] width,
  input  logic [1:0]       err_sel,
  input  logic [1:0]       cnt_sel,
  input  logic             recheck,
  output logic             lock
);
  logic [CNT_W-1:0] cnt_q, cnt_d, target, cnt_inc;
  logic [WID_W-1:0] limit;
  logic             lock_q, lock_d, good;

  always_comb begin
    limit   = WID_W'(2) << err_sel;
    target  = CNT_W'(4) << {cnt_sel, 1'b0};
    good    = (width <= limit);
    cnt_inc = cnt_q + CNT_W'(1);
    cnt_d   = cnt_q;
    lock_d  = lock_q;
    if (clr) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (tick) begin
      if (lock_q) begin
        if (recheck && !good) begin
          lock_d = 1'b0;
          cnt_d  = '0;
        end
      end else if (good) begin
        if (cnt_inc == target) begin
          lock_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;
endmodule

// File: rtl/lockdet_pa_gate.sv
module lockdet_pa_gate
  import lockdet_pkg::*;
(
  input  logic [1:0] op_mode,
  input  logic       lock,
  input  logic       pa_auto_off,
  output logic       pa_en
);
  always_comb begin
    pa_en = (opmode_e'(op_mode) == OPM_TX) && (pa_auto_off || lock);
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import lockdet_pkg::*;
#(
  parameter int MAX_WIN = 16,
  parameter int MAX_CNT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_up,
  input  logic       pfd_dn,
  input  logic       ref_tick,
  input  logic [1:0] err_sel,
  input  logic [1:0] cnt_sel,
  input  logic       recheck,
  input  logic       pa_auto_off,
  input  logic [1:0] op_mode,
  input  logic       ratio_chg,
  output logic       lock,
  output logic       pa_en
);
  localparam int WID_W = $clog2(MAX_WIN + 1);
  localparam int CNT_W = $clog2(MAX_CNT + 1);

  logic             clr;
  logic [WID_W-1:0] width;

  assign clr = (opmode_e'(op_mode) == OPM_STBY) || ratio_chg;

  lockdet_width_meter #(.WID_W(WID_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .up(pfd_up), .dn(pfd_dn),
    .tick(ref_tick), .clr(clr), .width(width)
  );

  lockdet_qualifier #(.WID_W(WID_W), .CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .clr(clr), .width(width),
    .err_sel(err_sel), .cnt_sel(cnt_sel), .recheck(recheck), .lock(lock)
  );

  lockdet_pa_gate u_pa (
    .op_mode(op_mode), .lock(lock), .pa_auto_off(pa_auto_off), .pa_en(pa_en)
  );
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic       recheck,
  input logic       pa_auto_off,
  input logic [1:0] op_mode,
  input logic       ratio_chg,
  input logic       lock,
  input logic       pa_en
);
  // R4: latched lock survives any cycle without a clear
  a_r4_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !recheck && op_mode != 2'b00 && !ratio_chg) |=> lock);

  // R6: standby or ratio change clears lock
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b00 || ratio_chg) |=> !lock);

  // R2: lock only rises after a reference strobe
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> !$rose(lock));

  // R7: no PA enable outside transmit
  a_r7_pa_off: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode != 2'b10) |-> !pa_en);

  // R8: automatic turn-on needs lock
  a_r8_pa_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_en && !pa_auto_off) |-> lock);

  // R9: disabled automatic turn-on follows transmit
  a_r9_pa_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == 2'b10 && pa_auto_off) |-> pa_en);
endmodule

bind pll_lock_detect lockdet_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .recheck(recheck),
  .pa_auto_off(pa_auto_off), .op_mode(op_mode), .ratio_chg(ratio_chg),
  .lock(lock), .pa_en(pa_en)
);

// File: tb/pll_lock_detect_test.sv
module pll_lock_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_up = 1'b0, pfd_dn = 1'b0, ref_tick = 1'b0;
  logic [1:0] err_sel = 2'd0, cnt_sel = 2'd0, op_mode = 2'b01;
  logic recheck = 1'b0, pa_auto_off = 1'b0, ratio_chg = 1'b0;
  logic lock, pa_en;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pll_lock_detect uut (
    .clk(clk), .rst_n(rst_n), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .ref_tick(ref_tick), .err_sel(err_sel), .cnt_sel(cnt_sel),
    .recheck(recheck), .pa_auto_off(pa_auto_off), .op_mode(op_mode),
    .ratio_chg(ratio_chg), .lock(lock), .pa_en(pa_en)
  );

  // fields: err_sel, cnt_sel, use_dn
  localparam int NV = 5;
  localparam logic [4:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0},
    {2'd1, 2'd1, 1'b0},
    {2'd2, 2'd2, 1'b1},
    {2'd3, 2'd3, 1'b0},
    {2'd3, 2'd0, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_cycle(input int w, input bit use_dn);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pfd_up   = !use_dn && (i < w);
      pfd_dn   = use_dn && (i < w);
      ref_tick = (i == 19);
    end
    @(negedge clk);
    pfd_up = 1'b0; pfd_dn = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic goods(input int n, input int w, input bit use_dn);
    for (int k = 0; k < n; k++) ref_cycle(w, use_dn);
  endtask

  task automatic standby_clear();
    @(negedge clk); op_mode = 2'b00;
    @(negedge clk); op_mode = 2'b01;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op_mode = 2'b10;
    repeat (3) @(negedge clk);
    check("R10 reset lock", lock, 1'b0);
    check("R10 reset pa_en", pa_en, 1'b0);
    rst_n = 1'b1;
    op_mode = 2'b01;

    // table: window and count for every field setting (R1, R2, R3, R11)
    for (int v = 0; v < NV; v++) begin
      int win, tgt;
      err_sel = VEC[v][4:3];
      cnt_sel = VEC[v][2:1];
      win = 2 << VEC[v][4:3];
      tgt = 4 << (2 * VEC[v][2:1]);
      recheck = 1'b0;
      standby_clear();
      goods(tgt - 1, win, VEC[v][0]);
      check("R2 before target", lock, 1'b0);
      ref_cycle(win + 1, VEC[v][0]);
      check("R1 over window is bad", lock, 1'b0);
      goods(tgt - 1, win, VEC[v][0]);
      check("R3 count restarted", lock, 1'b0);
      ref_cycle(win, VEC[v][0]);
      check(VEC[v][0] ? "R11 down pulses lock" : "R2 lock at target", lock, 1'b1);
    end

    // R4: latched mode ignores bad periods
    err_sel = 2'd0; cnt_sel = 2'd0; recheck = 1'b0;
    ref_cycle(20, 1'b0);
    check("R4 latched after bad", lock, 1'b1);

    // R5: monitoring mode drops lock on the bad period
    recheck = 1'b1;
    ref_cycle(1, 1'b0);
    check("R5 good keeps lock", lock, 1'b1);
    ref_cycle(3, 1'b0);
    check("R5 bad drops lock", lock, 1'b0);
    goods(3, 2, 1'b0);
    check("R5 relock needs full count", lock, 1'b0);
    ref_cycle(0, 1'b0);
    check("R5 relocked", lock, 1'b1);

    // R6: ratio change clears lock and count
    @(negedge clk); ratio_chg = 1'b1;
    @(negedge clk); ratio_chg = 1'b0;
    check("R6 ratio change clears", lock, 1'b0);
    goods(3, 2, 1'b0);
    check("R6 count cleared", lock, 1'b0);
    ref_cycle(2, 1'b0);
    check("R6 relock after ratio", lock, 1'b1);

    // R7/R8/R9: PA gating
    @(negedge clk);
    check("R7 receive no pa", pa_en, 1'b0);
    op_mode = 2'b11; #1;
    check("R7 idle no pa", pa_en, 1'b0);
    op_mode = 2'b10; #1;
    check("R8 tx locked pa on", pa_en, 1'b1);
    standby_clear();
    op_mode = 2'b10; #1;
    check("R6 standby clears", lock, 1'b0);
    check("R8 tx unlocked pa off", pa_en, 1'b0);
    pa_auto_off = 1'b1; #1;
    check("R9 auto off pa follows tx", pa_en, 1'b1);
    op_mode = 2'b01; #1;
    check("R7 rx with auto off", pa_en, 1'b0);
    pa_auto_off = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule